// File: doc/BRIEF.md
# Mode-Byte and Scale-Index-Base Operand Address Decoder

This block sits behind the prefix and opcode stages of a byte-serial instruction front end. It accepts the remaining bytes of one instruction over a valid/ready handshake. The first byte is always the mode byte. Depending on that byte, the block may then take a scale-index-base byte, an 8-bit or 32-bit displacement, and finally an immediate whose size comes from a hint supplied by the opcode stage.

When the last expected byte has been taken, the block raises a one-cycle done strobe. During that strobe it presents the following:
- the effective memory address, built from a 32-bit register file through two combinational read ports, or a flag saying that the operand is a register;
- both register numbers;
- the immediate value;
- the count of bytes consumed, counted from the mode byte onward.

It then waits for the next mode byte. Segment bases, opcode decoding and the 16-bit addressing forms are handled elsewhere.

Top module: `mrm_addr_decoder`

## Requirements
- R1: After reset, `done` is low and `in_ready` is high, and the first byte accepted is treated as a mode byte.
- R2: A mode byte with bits 7:6 = 11 selects a register operand: at done `is_reg`=1, `ea`=0, `reg_num` is bits 5:3, `rm_num` is bits 2:0, and no displacement bytes are consumed.
- R3: Mode 00 with bits 2:0 other than 100 and 101 gives `ea` equal to the register named by bits 2:0, with no displacement.
- R4: Mode 01 takes one displacement byte, sign-extends it to 32 bits and adds it to the base.
- R5: Mode 10 takes four displacement bytes, assembled least significant byte first, and adds them to the base with modulo-2^32 wrap.
- R6: Mode 00 with bits 2:0 = 101 takes a four-byte displacement that is used as the absolute address, with no base register.
- R7: Bits 2:0 = 100 with mode other than 11 causes one scale-index-base byte to follow: scale in bits 7:6, index in bits 5:3, base in bits 2:0. The address is base + (index × 2^scale) + displacement, giving factors of 1, 2, 4 and 8.
- R8: An index field of 100 contributes no index term.
- R9: A base field of 101 with mode 00 replaces the base register with a four-byte displacement. With modes 01 or 10, the same base field reads register 5 as usual.
- R10: `imm_code` is sampled together with the mode byte. Codes 00, 01, 10 and 11 select 0, 1, 2 and 4 immediate bytes. These bytes are assembled least significant first and zero-extended on `imm`.
- R11: `done` is high for exactly one cycle, beginning the cycle after the last byte is accepted. During that cycle `in_ready` is low and `len` equals the number of bytes accepted for the instruction, including the mode byte. In the following cycle `in_ready` is high again.
- R12: Cycles with `in_valid` low consume nothing and do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte value |
| in_ready | output | 1 | Byte will be taken this cycle |
| imm_code | input | 2 | Immediate size hint, sampled with the mode byte |
| rf_a_sel | output | 3 | Base register read select |
| rf_a_data | input | ADDR_W | Base register read data |
| rf_b_sel | output | 3 | Index register read select |
| rf_b_data | input | ADDR_W | Index register read data |
| done | output | 1 | Result strobe |
| is_reg | output | 1 | Operand is a register, not memory |
| reg_num | output | 3 | Register field of the mode byte |
| rm_num | output | 3 | Register/memory field of the mode byte |
| ea | output | ADDR_W | Effective address |
| imm | output | 32 | Immediate value |
| len | output | LEN_W | Bytes consumed, mode byte included |

## Verification
The checker watches the handshake shape on every cycle:
- `done` lasts one cycle and stalls input while high;
- input reopens right after `done`;
- register operands report a zero address and a short length;
- `len` stays within its legal range.

The actual arithmetic can only be shown by the bench scenarios, which compare against an independent model:
- the sign extension of short displacements;
- the scale factors;
- the no-index and no-base escapes;
- the sampling of the immediate hint;
- immunity to idle cycles.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

   typedef enum logic [2:0] {
      PS_MODE,
      PS_SIB,
      PS_DISP,
      PS_IMM,
      PS_DONE
   } parse_st_t;

   localparam logic [1:0] MD_IND  = 2'b00;
   localparam logic [1:0] MD_D8   = 2'b01;
   localparam logic [1:0] MD_DW   = 2'b10;
   localparam logic [1:0] MD_REG  = 2'b11;
   localparam logic [2:0] RM_ESC  = 3'b100;
   localparam logic [2:0] RM_ABS  = 3'b101;
   localparam logic [2:0] IX_NONE = 3'b100;

   localparam int IMM_MAX_B = 4;

   function automatic int unsigned imm_bytes(input logic [1:0] code);
      case (code)
         2'b00:   return 0;
         2'b01:   return 1;
         2'b10:   return 2;
         default: return 4;
      endcase
   endfunction

   // displacement length once the mode byte is known (no scale-index-base byte)
   function automatic int unsigned disp_after_mode(input logic [1:0] md, input logic [2:0] rm,
                                                   input int unsigned wide);
      if (md == MD_D8)                      return 1;
      if (md == MD_DW)                      return wide;
      if (md == MD_IND && rm == RM_ABS)     return wide;
      return 0;
   endfunction

   // displacement length once the scale-index-base byte is known
   function automatic int unsigned disp_after_sib(input logic [1:0] md, input logic [2:0] bs,
                                                  input int unsigned wide);
      if (md == MD_D8)                      return 1;
      if (md == MD_DW)                      return wide;
      if (md == MD_IND && bs == RM_ABS)     return wide;
      return 0;
   endfunction

endpackage

// File: rtl/mrm_le_acc.sv
module mrm_le_acc #(
   parameter int BYTES = 4,
   parameter int POS_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 we,
   input  logic [POS_W-1:0]     pos,
   input  logic [7:0]           din,
   output logic [BYTES*8-1:0]   value
);

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            value[g*8 +: 8] <= '0;
         else if (clr)
            value[g*8 +: 8] <= '0;
         else if (we && pos == POS_W'(g))
            value[g*8 +: 8] <= din;
      end
   end

endmodule

// File: rtl/mrm_seq.sv
module mrm_seq
   import mrm_pkg::*;
#(
   parameter int DISP_BYTES = 4,
   parameter int CNT_W      = 3,
   parameter int LEN_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [7:0]       in_data,
   input  logic [1:0]       imm_code,
   output logic             in_ready,
   output logic             done,
   output logic             mode_we,
   output logic             disp_we,
   output logic             imm_we,
   output logic [CNT_W-1:0] byte_pos,
   output logic [1:0]       mod_q,
   output logic [2:0]       reg_q,
   output logic [2:0]       rm_q,
   output logic [1:0]       ss_q,
   output logic [2:0]       ix_q,
   output logic [2:0]       bs_q,
   output logic [LEN_W-1:0] len_q
);

   parse_st_t        st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d, pos_q, pos_d, ilen_q, ilen_new;
   logic             accept, sib_we;
   int unsigned      dl_mode, dl_sib;

   assign in_ready = (st_q != PS_DONE);
   assign accept   = in_valid && in_ready;
   assign mode_we  = accept && st_q == PS_MODE;
   assign sib_we   = accept && st_q == PS_SIB;
   assign disp_we  = accept && st_q == PS_DISP;
   assign imm_we   = accept && st_q == PS_IMM;
   assign done     = (st_q == PS_DONE);
   assign byte_pos = pos_q;
   assign ilen_new = CNT_W'(imm_bytes(imm_code));

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      pos_d   = pos_q;
      dl_mode = disp_after_mode(in_data[7:6], in_data[2:0], DISP_BYTES);
      dl_sib  = disp_after_sib(mod_q, in_data[2:0], DISP_BYTES);
      if (st_q == PS_DONE) begin
         st_d = PS_MODE;
      end else if (accept) begin
         unique case (st_q)
            PS_MODE: begin
               pos_d = '0;
               if (in_data[7:6] != MD_REG && in_data[2:0] == RM_ESC) begin
                  st_d = PS_SIB;
               end else if (dl_mode != 0) begin
                  st_d  = PS_DISP;
                  cnt_d = CNT_W'(dl_mode);
               end else if (ilen_new != '0) begin
                  st_d  = PS_IMM;
                  cnt_d = ilen_new;
               end else begin
                  st_d = PS_DONE;
               end
            end
            PS_SIB: begin
               pos_d = '0;
               if (dl_sib != 0) begin
                  st_d  = PS_DISP;
                  cnt_d = CNT_W'(dl_sib);
               end else if (ilen_q != '0) begin
                  st_d  = PS_IMM;
                  cnt_d = ilen_q;
               end else begin
                  st_d = PS_DONE;
               end
            end
            PS_DISP: begin
               pos_d = pos_q + 1'b1;
               cnt_d = cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) begin
                  pos_d = '0;
                  if (ilen_q != '0) begin
                     st_d  = PS_IMM;
                     cnt_d = ilen_q;
                  end else begin
                     st_d = PS_DONE;
                  end
               end
            end
            PS_IMM: begin
               pos_d = pos_q + 1'b1;
               cnt_d = cnt_q - 1'b1;
               if (cnt_q == CNT_W'(1)) st_d = PS_DONE;
            end
            default: st_d = PS_MODE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PS_MODE;
         cnt_q  <= '0;
         pos_q  <= '0;
         ilen_q <= '0;
         len_q  <= '0;
         mod_q  <= '0;
         reg_q  <= '0;
         rm_q   <= '0;
         ss_q   <= '0;
         ix_q   <= '0;
         bs_q   <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
         pos_q <= pos_d;
         if (mode_we) begin
            mod_q  <= in_data[7:6];
            reg_q  <= in_data[5:3];
            rm_q   <= in_data[2:0];
            ilen_q <= ilen_new;
            len_q  <= LEN_W'(1);
         end else if (accept) begin
            len_q <= len_q + 1'b1;
         end
         if (sib_we) begin
            ss_q <= in_data[7:6];
            ix_q <= in_data[5:3];
            bs_q <= in_data[2:0];
         end
      end
   end

endmodule

// File: rtl/mrm_agu.sv
module mrm_agu
   import mrm_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [1:0]        mod_q,
   input  logic [2:0]        rm_q,
   input  logic [1:0]        ss_q,
   input  logic [2:0]        ix_q,
   input  logic [2:0]        bs_q,
   input  logic [ADDR_W-1:0] disp_raw,
   input  logic [ADDR_W-1:0] rf_a_data,
   input  logic [ADDR_W-1:0] rf_b_data,
   output logic [2:0]        rf_a_sel,
   output logic [2:0]        rf_b_sel,
   output logic              is_reg,
   output logic [ADDR_W-1:0] ea
);

   logic              has_sib, no_base;
   logic [ADDR_W-1:0] disp_ext, base_v, idx_v;

   assign is_reg   = (mod_q == MD_REG);
   assign has_sib  = !is_reg && rm_q == RM_ESC;
   assign no_base  = (mod_q == MD_IND) && (has_sib ? (bs_q == RM_ABS) : (rm_q == RM_ABS));
   assign rf_a_sel = has_sib ? bs_q : rm_q;
   assign rf_b_sel = ix_q;

   assign disp_ext = (mod_q == MD_D8) ? {{(ADDR_W-8){disp_raw[7]}}, disp_raw[7:0]} : disp_raw;
   assign base_v   = no_base ? '0 : rf_a_data;
   assign idx_v    = (has_sib && ix_q != IX_NONE) ? (rf_b_data << ss_q) : '0;
   assign ea       = is_reg ? '0 : (base_v + idx_v + disp_ext);

endmodule

// File: rtl/mrm_addr_decoder.sv
module mrm_addr_decoder
   import mrm_pkg::*;
#(
   parameter int  ADDR_W = 32,
   localparam int LEN_W  = $clog2(ADDR_W/8 + IMM_MAX_B + 3)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   input  logic [1:0]        imm_code,
   output logic [2:0]        rf_a_sel,
   input  logic [ADDR_W-1:0] rf_a_data,
   output logic [2:0]        rf_b_sel,
   input  logic [ADDR_W-1:0] rf_b_data,
   output logic              done,
   output logic              is_reg,
   output logic [2:0]        reg_num,
   output logic [2:0]        rm_num,
   output logic [ADDR_W-1:0] ea,
   output logic [31:0]       imm,
   output logic [LEN_W-1:0]  len
);

   localparam int DISP_BYTES = ADDR_W / 8;
   localparam int MAX_FIELD  = (DISP_BYTES > IMM_MAX_B) ? DISP_BYTES : IMM_MAX_B;
   localparam int CNT_W      = $clog2(MAX_FIELD + 1);

   initial begin
      if (ADDR_W % 8 != 0 || ADDR_W < 16)
         $fatal(1, "mrm_addr_decoder: ADDR_W must be a multiple of 8 and at least 16");
   end

   logic             mode_we, disp_we, imm_we;
   logic [CNT_W-1:0] byte_pos;
   logic [1:0]       mod_q, ss_q;
   logic [2:0]       reg_q, rm_q, ix_q, bs_q;
   logic [ADDR_W-1:0] disp_raw;

   mrm_seq #(.DISP_BYTES(DISP_BYTES), .CNT_W(CNT_W), .LEN_W(LEN_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .imm_code(imm_code), .in_ready(in_ready), .done(done),
      .mode_we(mode_we), .disp_we(disp_we), .imm_we(imm_we), .byte_pos(byte_pos),
      .mod_q(mod_q), .reg_q(reg_q), .rm_q(rm_q), .ss_q(ss_q), .ix_q(ix_q),
      .bs_q(bs_q), .len_q(len)
   );

   mrm_le_acc #(.BYTES(DISP_BYTES), .POS_W(CNT_W)) disp_acc_i (
      .clk(clk), .rst_n(rst_n), .clr(mode_we), .we(disp_we),
      .pos(byte_pos), .din(in_data), .value(disp_raw)
   );

   mrm_le_acc #(.BYTES(IMM_MAX_B), .POS_W(CNT_W)) imm_acc_i (
      .clk(clk), .rst_n(rst_n), .clr(mode_we), .we(imm_we),
      .pos(byte_pos), .din(in_data), .value(imm)
   );

   mrm_agu #(.ADDR_W(ADDR_W)) agu_i (
      .mod_q(mod_q), .rm_q(rm_q), .ss_q(ss_q), .ix_q(ix_q), .bs_q(bs_q),
      .disp_raw(disp_raw), .rf_a_data(rf_a_data), .rf_b_data(rf_b_data),
      .rf_a_sel(rf_a_sel), .rf_b_sel(rf_b_sel), .is_reg(is_reg), .ea(ea)
   );

   assign reg_num = reg_q;
   assign rm_num  = rm_q;

endmodule

// File: rtl/mrm_addr_decoder_chk.sv
module mrm_addr_decoder_chk #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              done,
   input logic              is_reg,
   input logic [ADDR_W-1:0] ea,
   input logic [LEN_W-1:0]  len
);

   localparam int MAX_LEN = 2 + ADDR_W/8 + mrm_pkg::IMM_MAX_B;

   // R1
   reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done);

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);

   // R11
   done_stall_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !in_ready);

   // R11
   ready_reopen_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> in_ready);

   // R11
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (len >= LEN_W'(1) && len <= LEN_W'(MAX_LEN)));

   // R2
   regop_zero_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_reg) |-> (ea == '0));

   // R2
   regop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && is_reg) |-> (len <= LEN_W'(1 + mrm_pkg::IMM_MAX_B)));

endmodule

bind mrm_addr_decoder mrm_addr_decoder_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .done(done),
   .is_reg(is_reg), .ea(ea), .len(len)
);

// File: tb/mrm_addr_decoder_tb_top.sv
module mrm_addr_decoder_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  in_data = 8'h00;
   logic        in_ready;
   logic [1:0]  imm_code = 2'b00;
   logic [2:0]  rf_a_sel, rf_b_sel;
   logic [31:0] rf_a_data, rf_b_data;
   logic        done, is_reg;
   logic [2:0]  reg_num, rm_num;
   logic [31:0] ea, imm;
   logic [3:0]  len;

   logic [31:0] rf [8];
   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   assign rf_a_data = rf[rf_a_sel];
   assign rf_b_data = rf[rf_b_sel];

   mrm_addr_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .imm_code(imm_code), .rf_a_sel(rf_a_sel),
      .rf_a_data(rf_a_data), .rf_b_sel(rf_b_sel), .rf_b_data(rf_b_data),
      .done(done), .is_reg(is_reg), .reg_num(reg_num), .rm_num(rm_num),
      .ea(ea), .imm(imm), .len(len)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc == 50000) begin
         errors++;
         $display("FAIL R11 watchdog: actual no completion, expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // behavioural model: build the byte stream, predict the result, drive and compare
   task automatic run_case(input string req, input logic [1:0] md, input logic [2:0] rg,
                           input logic [2:0] rm, input logic [1:0] ss, input logic [2:0] ix,
                           input logic [2:0] bs, input logic [31:0] dsp, input logic [31:0] iv,
                           input logic [1:0] code, input int gap_at);
      logic [7:0]  q[$];
      bit          sib, nobase;
      int          dn, inb;
      logic [31:0] e_ea, e_imm, b, x, d;
      q.push_back({md, rg, rm});
      sib = (md != 2'b11) && (rm == 3'b100);
      if (sib) q.push_back({ss, ix, bs});
      if (md == 2'b01) dn = 1;
      else if (md == 2'b10) dn = 4;
      else if (md == 2'b00 && (sib ? bs == 3'b101 : rm == 3'b101)) dn = 4;
      else dn = 0;
      for (int k = 0; k < dn; k++) q.push_back(dsp[8*k +: 8]);
      inb = (code == 2'b11) ? 4 : int'(code);
      for (int k = 0; k < inb; k++) q.push_back(iv[8*k +: 8]);
      e_imm = 0;
      for (int k = 0; k < inb; k++) e_imm[8*k +: 8] = iv[8*k +: 8];
      if (md == 2'b11) begin
         e_ea = 0;
      end else begin
         nobase = (md == 2'b00) && (sib ? bs == 3'b101 : rm == 3'b101);
         b = nobase ? 32'h0 : rf[sib ? bs : rm];
         x = (sib && ix != 3'b100) ? rf[ix] * (32'd1 << ss) : 32'h0;
         d = (dn == 1) ? {{24{dsp[7]}}, dsp[7:0]} : (dn == 4 ? dsp : 32'h0);
         e_ea = b + x + d;
      end
      for (int k = 0; k < q.size(); k++) begin
         if (k == gap_at) begin
            @(negedge clk);
            chk("R12", "done during idle", {31'b0, done}, 32'h0);
            in_valid = 1'b0;
            in_data  = 8'hFF;
            imm_code = ~code;
         end
         @(negedge clk);
         if (done !== 1'b0 || in_ready !== 1'b1)
            chk("R11", "busy handshake", {30'b0, done, in_ready}, 32'h1);
         in_valid = 1'b1;
         in_data  = q[k];
         imm_code = (k == 0) ? code : ~code;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'hEE;
      chk("R11", {req, " done"}, {31'b0, done}, 32'h1);
      chk("R11", {req, " ready low"}, {31'b0, in_ready}, 32'h0);
      chk(req, "is_reg", {31'b0, is_reg}, {31'b0, md == 2'b11});
      chk(req, "ea", ea, e_ea);
      chk("R10", {req, " imm"}, imm, e_imm);
      chk("R11", {req, " len"}, {28'b0, len}, q.size());
      chk("R2", {req, " reg_num"}, {29'b0, reg_num}, {29'b0, rg});
      chk("R2", {req, " rm_num"}, {29'b0, rm_num}, {29'b0, rm});
      @(negedge clk);
      chk("R11", {req, " after done"}, {30'b0, done, in_ready}, 32'h1);
   endtask

   initial begin
      rf[0] = 32'h0000_1000; rf[1] = 32'h0000_0200; rf[2] = 32'h0000_0030;
      rf[3] = 32'h8000_0000; rf[4] = 32'h0001_0000; rf[5] = 32'h0000_7000;
      rf[6] = 32'hFFFF_FFF0; rf[7] = 32'h1234_0000;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "done in reset", {31'b0, done}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "ready after reset", {31'b0, in_ready}, 32'h1);
      chk("R1", "done after reset", {31'b0, done}, 32'h0);

      run_case("R2", 2'b11, 3'd2, 3'd6, 2'd0, 3'd0, 3'd0, 32'h0, 32'h0, 2'b00, -1);
      run_case("R2", 2'b11, 3'd1, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0, 32'hDEAD_BEEF, 2'b11, -1);
      run_case("R3", 2'b00, 3'd5, 3'd3, 2'd0, 3'd0, 3'd0, 32'h0, 32'h0, 2'b00, -1);
      run_case("R4", 2'b01, 3'd0, 3'd1, 2'd0, 3'd0, 3'd0, 32'h0000_00FC, 32'h0, 2'b00, -1);
      run_case("R4", 2'b01, 3'd3, 3'd7, 2'd0, 3'd0, 3'd0, 32'h0000_007F, 32'h5A, 2'b01, -1);
      run_case("R5", 2'b10, 3'd4, 3'd6, 2'd0, 3'd0, 3'd0, 32'h0000_0020, 32'hABCD_1234, 2'b10, -1);
      run_case("R5", 2'b10, 3'd7, 3'd2, 2'd0, 3'd0, 3'd0, 32'h1122_3344, 32'h0, 2'b00, -1);
      run_case("R6", 2'b00, 3'd6, 3'd5, 2'd0, 3'd0, 3'd0, 32'h00C0_FFEE, 32'h0, 2'b00, -1);
      for (int s = 0; s < 4; s++)
         run_case("R7", 2'b00, 3'd2, 3'd4, 2'(s), 3'd1, 3'd0, 32'h0, 32'h0, 2'b00, -1);
      run_case("R7", 2'b01, 3'd1, 3'd4, 2'd2, 3'd7, 3'd6, 32'h0000_0081, 32'h77, 2'b01, -1);
      run_case("R8", 2'b10, 3'd0, 3'd4, 2'd3, 3'd4, 3'd2, 32'h0000_0100, 32'h0, 2'b00, -1);
      run_case("R8", 2'b00, 3'd0, 3'd4, 2'd0, 3'd4, 3'd4, 32'h0, 32'h0, 2'b00, -1);
      run_case("R9", 2'b00, 3'd3, 3'd4, 2'd3, 3'd2, 3'd5, 32'h4000_0000, 32'h0, 2'b00, -1);
      run_case("R9", 2'b01, 3'd3, 3'd4, 2'd1, 3'd0, 3'd5, 32'h0000_0080, 32'h0, 2'b00, -1);
      run_case("R10", 2'b00, 3'd1, 3'd0, 2'd0, 3'd0, 3'd0, 32'h0, 32'hCAFE_F00D, 2'b10, -1);
      // R12: idle cycles with junk data and a changed hint inside an instruction
      run_case("R12", 2'b00, 3'd3, 3'd4, 2'd3, 3'd2, 3'd5, 32'h0123_4567, 32'h89AB, 2'b10, 1);
      run_case("R12", 2'b01, 3'd3, 3'd7, 2'd0, 3'd0, 3'd0, 32'h0000_00F0, 32'h5A, 2'b01, 2);
      run_case("R12", 2'b11, 3'd5, 3'd3, 2'd0, 3'd0, 3'd0, 32'h0, 32'h1234_5678, 2'b11, 3);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule